// File: doc/BRIEF.md
# Stereo Soft Mute Gain Ramp

This block sits in the digital path ahead of a stereo DAC and fades the audio in and out without a click. A mute request input selects the direction of travel. A frame strobe pulses once per sample frame, and each pulse moves an internal gain one step along a linear ramp. The ramp runs between silence (gain 0) and unity (gain 1024). The same gain multiplies both the left and the right sample.

Samples are 20-bit two's-complement words. 7FFFFh is positive full scale and 80000h is negative full scale. Each output sample is the input times the gain, divided by 1024, with the quotient truncated toward zero. The result leaves a register one clock after the input is presented.

Two status flags report when the ramp is parked at one of its ends. If the request flips partway through a ramp, the gain turns around from wherever it is. It does not restart from an end.

Top module: `soft_mute_ramp`

## Requirements
- R1: While `rst` is high at a clock edge, the gain is set to unity (1024), `at_unity` reads 1, `at_silence` reads 0, and both sample outputs read 0.
- R2: With `mute_req` high, each clock with `frame_tick` high lowers the gain by one. Starting from unity, exactly 1024 such ticks bring it to 0.
- R3: With `mute_req` low, each clock with `frame_tick` high raises the gain by one. Starting from 0, exactly 1024 such ticks bring it to unity.
- R4: A change of `mute_req` in the middle of a ramp reverses the direction from the present gain. After 300 downward ticks from unity and a release, 300 upward ticks restore unity, and `at_silence` never rises.
- R5: The gain is unchanged on clocks with `frame_tick` low. It does not go below 0 or above 1024, whatever the request.
- R6: One clock after the inputs are presented, each output equals its own channel's input times the gain, divided by 1024 and truncated toward zero. Outputs are signed 20-bit values, and both channels use the same gain.
- R7: When the gain is 0, both outputs are exactly 0 for every input, including full-scale values.
- R8: When the gain is 1024, both outputs equal their inputs bit for bit.
- R9: `at_silence` is 1 exactly when the gain is 0, and `at_unity` is 1 exactly when the gain is 1024. The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-clock strobe per sample frame; advances the ramp |
| mute_req | input | 1 | 1 ramps toward silence, 0 ramps toward unity |
| in_l | input | 20 | Left sample, two's complement |
| in_r | input | 20 | Right sample, two's complement |
| out_l | output | 20 | Scaled left sample, registered |
| out_r | output | 20 | Scaled right sample, registered |
| at_silence | output | 1 | Gain is 0 |
| at_unity | output | 1 | Gain is 1024 |

## Verification
The assertions take only two things for granted: reset is high at the first clock edge, and every input is driven to a known level after that. The frame strobe may follow any pattern, including high on consecutive clocks or low for long stretches, and no assertion assumes a spacing between pulses. The stimulus respects this. It holds reset from time zero, drives every input on every cycle, and pulses the strobe on most cycles with regular gaps. Samples change each cycle and include both full-scale codes, minus one and small odd values, so that the truncation sign and the hold behaviour are both exercised.

// File: rtl/smr_pkg.sv
package smr_pkg;

  localparam int DEF_DATA_W    = 20;
  localparam int DEF_RAMP_LOG2 = 10;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_DOWN = 2'd1,
    DIR_UP   = 2'd2
  } ramp_dir_t;

endpackage

// File: rtl/smr_gain_ctrl.sv
module smr_gain_ctrl
  import smr_pkg::*;
#(
  parameter int RAMP_LOG2 = DEF_RAMP_LOG2,
  localparam int GAIN_W   = RAMP_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_tick,
  input  logic              mute_req,
  output logic [GAIN_W-1:0] gain,
  output logic              at_silence,
  output logic              at_unity
);

  localparam logic [GAIN_W-1:0] G_UNITY = GAIN_W'(1 << RAMP_LOG2);
  localparam logic [GAIN_W-1:0] G_ZERO  = '0;

  logic [GAIN_W-1:0] gain_q, gain_d;
  ramp_dir_t         dir;
  logic              silent_q, unity_q;

  // direction decision: the request picks the way, the end stops pick hold
  always_comb begin
    dir = DIR_HOLD;
    if (frame_tick) begin
      if (mute_req && gain_q != G_ZERO)
        dir = DIR_DOWN;
      else if (!mute_req && gain_q != G_UNITY)
        dir = DIR_UP;
    end
  end

  always_comb begin
    unique case (dir)
      DIR_DOWN: gain_d = gain_q - 1'b1;
      DIR_UP:   gain_d = gain_q + 1'b1;
      default:  gain_d = gain_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q   <= G_UNITY;
      silent_q <= 1'b0;
      unity_q  <= 1'b1;
    end else begin
      gain_q   <= gain_d;
      silent_q <= (gain_d == G_ZERO);
      unity_q  <= (gain_d == G_UNITY);
    end
  end

  assign gain       = gain_q;
  assign at_silence = silent_q;
  assign at_unity   = unity_q;

  // R2: downward step of exactly one per tick
  p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && mute_req && gain_q != G_ZERO) |=> gain_q == $past(gain_q) - 1'b1);

  // R3: upward step of exactly one per tick
  p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && !mute_req && gain_q != G_UNITY) |=> gain_q == $past(gain_q) + 1'b1);

  // R5: no movement without a tick
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(gain_q));

  // R5: never above unity
  p_range_r5: assert property (@(posedge clk) disable iff (rst)
    gain_q <= G_UNITY);

endmodule

// File: rtl/smr_scaler.sv
module smr_scaler
  import smr_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int RAMP_LOG2 = DEF_RAMP_LOG2,
  localparam int GAIN_W   = RAMP_LOG2 + 1,
  localparam int PROD_W   = DATA_W + GAIN_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] din,
  input  logic        [GAIN_W-1:0] gain,
  output logic signed [DATA_W-1:0] dout
);

  // added to negative products so the arithmetic shift truncates toward zero
  localparam logic signed [PROD_W-1:0] TRUNC_BIAS =
    {{(PROD_W-RAMP_LOG2){1'b0}}, {RAMP_LOG2{1'b1}}};

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] bias;
  logic signed [DATA_W-1:0] scaled;
  logic signed [DATA_W-1:0] dout_q;

  always_comb begin
    prod   = din * $signed({1'b0, gain});
    bias   = prod[PROD_W-1] ? TRUNC_BIAS : '0;
    scaled = DATA_W'((prod + bias) >>> RAMP_LOG2);
  end

  always_ff @(posedge clk) begin
    if (rst) dout_q <= '0;
    else     dout_q <= scaled;
  end

  assign dout = dout_q;

  // R6: truncation toward zero never flips or invents a sign
  p_sign_pos_r6: assert property (@(posedge clk) disable iff (rst)
    (din >= 0) |=> (dout >= 0));

  p_sign_neg_r6: assert property (@(posedge clk) disable iff (rst)
    (din < 0) |=> (dout <= 0));

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
  import smr_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int RAMP_LOG2 = DEF_RAMP_LOG2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frame_tick,
  input  logic                     mute_req,
  input  logic signed [DATA_W-1:0] in_l,
  input  logic signed [DATA_W-1:0] in_r,
  output logic signed [DATA_W-1:0] out_l,
  output logic signed [DATA_W-1:0] out_r,
  output logic                     at_silence,
  output logic                     at_unity
);

  localparam int GAIN_W = RAMP_LOG2 + 1;
  localparam int N_CH   = 2;

  logic [GAIN_W-1:0]        gain;
  logic signed [DATA_W-1:0] ch_in  [N_CH];
  logic signed [DATA_W-1:0] ch_out [N_CH];

  smr_gain_ctrl #(.RAMP_LOG2(RAMP_LOG2)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .frame_tick (frame_tick),
    .mute_req   (mute_req),
    .gain       (gain),
    .at_silence (at_silence),
    .at_unity   (at_unity)
  );

  assign ch_in[0] = in_l;
  assign ch_in[1] = in_r;

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    smr_scaler #(.DATA_W(DATA_W), .RAMP_LOG2(RAMP_LOG2)) u_scale (
      .clk  (clk),
      .rst  (rst),
      .din  (ch_in[c]),
      .gain (gain),
      .dout (ch_out[c])
    );
  end

  assign out_l = ch_out[0];
  assign out_r = ch_out[1];

  // R7: silence flag means the next outputs are zero
  p_silent_zero_r7: assert property (@(posedge clk) disable iff (rst)
    at_silence |=> (out_l == '0 && out_r == '0));

  // R8: unity flag means the next outputs copy the inputs
  p_unity_pass_r8: assert property (@(posedge clk) disable iff (rst)
    at_unity |=> (out_l == $past(in_l) && out_r == $past(in_r)));

  // R9: the two end flags exclude each other
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(at_silence && at_unity));

endmodule

// File: tb/soft_mute_ramp_bench.sv
module soft_mute_ramp_bench;

  localparam int DW    = 20;
  localparam int UNITY = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_tick = 1'b0;
  logic mute_req = 1'b0;
  logic signed [DW-1:0] in_l = '0, in_r = '0;
  logic signed [DW-1:0] out_l, out_r;
  logic at_silence, at_unity;

  int n_checks = 0;
  int n_fail   = 0;
  int g_model  = UNITY;
  int lcg      = 12345;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  soft_mute_ramp u_soft_mute_ramp (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .mute_req(mute_req),
    .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r),
    .at_silence(at_silence), .at_unity(at_unity)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int scale(input int x, input int g);
    return (x * g) / UNITY;
  endfunction

  function automatic int pick(input int k);
    case (k % 8)
      0: return 524287;
      1: return -524288;
      2: return -1;
      3: return 1;
      4: return 0;
      5: return -3;
      default: begin
        lcg = lcg * 1103515245 + 12345;
        return ((lcg >>> 8) % 524288);
      end
    endcase
  endfunction

  // one clock: inputs set at a falling edge, results checked at the next one
  task automatic step(input bit tick, input bit req, input int xl, input int xr);
    int el, er;
    string tag;
    frame_tick = tick;
    mute_req   = req;
    in_l = DW'(xl);
    in_r = DW'(xr);
    el = scale(xl, g_model);
    er = scale(xr, g_model);
    tag = (g_model == 0) ? "R7" : (g_model == UNITY) ? "R8" : "R6";
    if (tick) begin
      if (req && g_model > 0) g_model--;
      else if (!req && g_model < UNITY) g_model++;
    end
    @(negedge clk);
    chk({tag, " left"},  int'(out_l), el);
    chk({tag, " right"}, int'(out_r), er);
    chk("R9 silence flag", int'(at_silence), int'(g_model == 0));
    chk("R9 unity flag",   int'(at_unity),   int'(g_model == UNITY));
  endtask

  initial begin
    int ticks;
    int k;
    bit saw_silence;
    @(negedge clk);
    @(negedge clk);
    // R1: state while reset is held
    chk("R1 out_l", int'(out_l), 0);
    chk("R1 out_r", int'(out_r), 0);
    chk("R1 unity", int'(at_unity), 1);
    chk("R1 silence", int'(at_silence), 0);
    rst = 1'b0;

    // R8 / R5: parked at unity, upward ticks do nothing
    for (int i = 0; i < 24; i++) step(1'b1, 1'b0, pick(i), pick(i + 3));

    // R2 / R5 / R6: full mute ramp with hold gaps
    ticks = 0; k = 0;
    while (g_model > 0) begin
      bit t = (k % 5) != 4;
      if (t) ticks++;
      step(t, 1'b1, pick(k), pick(k + 5));
      k++;
    end
    chk("R2 ticks to silence", ticks, 1024);

    // R7 / R5: parked at silence, full-scale inputs give zero
    for (int i = 0; i < 24; i++) step(1'b1, 1'b1, pick(i), pick(i + 1));

    // R3: full unmute ramp
    ticks = 0; k = 0;
    while (g_model < UNITY) begin
      bit t = (k % 7) != 6;
      if (t) ticks++;
      step(t, 1'b0, pick(k + 2), pick(k + 6));
      k++;
    end
    chk("R3 ticks to unity", ticks, 1024);
    chk("R3 unity flag", int'(at_unity), 1);

    // R4: release after 300 downward ticks, turn around from the present gain
    for (int i = 0; i < 300; i++) step(1'b1, 1'b1, pick(i), pick(i + 4));
    ticks = 0; saw_silence = 1'b0;
    while (g_model < UNITY) begin
      ticks++;
      step(1'b1, 1'b0, pick(ticks), pick(ticks + 2));
      if (at_silence) saw_silence = 1'b1;
    end
    chk("R4 ticks back to unity", ticks, 300);
    chk("R4 silence never seen", int'(saw_silence), 0);

    // R4: reverse twice mid-ramp
    for (int i = 0; i < 50; i++) step(1'b1, 1'b1, pick(i), pick(i + 7));
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, pick(i), pick(i + 7));
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, pick(i), pick(i + 7));
    for (int i = 0; i < 8;  i++) step(1'b0, 1'b0, pick(i), pick(i + 1));
    while (g_model < UNITY) step(1'b1, 1'b0, 524287, -524288);
    step(1'b0, 1'b0, -524288, 524287);

    // R1: reset mid-ramp returns to unity
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, pick(i), pick(i));
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    g_model = UNITY;
    chk("R1 unity after reset", int'(at_unity), 1);
    chk("R1 out after reset", int'(out_l), 0);
    step(1'b0, 1'b1, 524287, -524288);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule